// File: doc/BRIEF.md
# Processor Trace Capture Controller

This block sits beside a CPU bus monitor and decides, one bus cycle at a time, whether the cycle should become an entry in an on-chip trace buffer. Each cycle it sees a valid strobe, the program counter, the bus address and data, a two-bit cycle type and a change-of-flow flag. A two-bit mode input selects one of four capture filters. The first keeps branch targets. The second does the same but drops an entry whose program counter repeats the one just stored. The third keeps address and data of data accesses. The fourth keeps the program counter of every opcode fetch.

An arm pulse clears the buffer and starts a session. It also latches the trigger alignment. With begin alignment, recording starts at the trigger from the external state sequencer and stops when the buffer fills. With end alignment, recording runs continuously into a circular buffer and stops at the trigger. A secure input and a debug-active input hold capture off. Breakpoint requests still follow the trigger while secure is high. Once the session is disarmed, a read port returns the entries oldest first through an auto-incrementing read offset.

Top module: `trace_capture`

## Requirements
- R1: After reset, `armed`, `done`, `brk_req` are 0 and `count` is 0.
- R2: With mode 0, a valid cycle with `cof`=1 stores `{pc, 0}`. Valid cycles with `cof`=0 store nothing.
- R3: With mode 1, the filter behaves as in mode 0, except that a change-of-flow cycle whose `pc` equals the last stored `pc` of the session is skipped. A repeat that is not consecutive is stored.
- R4: With mode 2, a valid cycle of type 2 or 3 (data access) stores `{addr, data}`. Type 0 (free) and type 1 (opcode fetch) store nothing, whatever `cof` is.
- R5: With mode 3, every valid cycle of type 1 stores `{pc, 0}`, whatever `cof` is. Other cycle types store nothing.
- R6: With begin alignment (`align_end`=0 at arm), nothing is stored before the trigger. The trigger cycle and later cycles are stored. After the DEPTH-th entry, `armed` drops and `done` rises in the same cycle.
- R7: With end alignment, storing starts at arm and wraps over the oldest entries. The trigger cycle is the last stored entry, and on it `armed` drops and `done` rises.
- R8: While `secure`=1 nothing is stored, but an armed trigger still gives `brk_req`=1 in the following cycle.
- R9: A cycle with `dbg_active`=1 stores nothing.
- R10: When not armed, `rd_en` returns the entry at the read offset on `rd_data` one cycle later and advances the offset, oldest entry first. `arm_set` or `arm_clr` rewinds the offset. While armed, `rd_en` leaves `rd_data` unchanged.
- R11: `count` counts stored entries of the session and saturates at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_set | input | 1 | Start session: clear buffer, latch alignment |
| arm_clr | input | 1 | Disarm and rewind read offset |
| align_end | input | 1 | 0 = begin alignment, 1 = end alignment |
| mode | input | 2 | Capture filter select (0..3) |
| trigger | input | 1 | Final-state trigger from the sequencer |
| secure | input | 1 | Blocks capture |
| dbg_active | input | 1 | Suspends monitoring |
| bus_valid | input | 1 | Bus cycle present |
| cyc_type | input | 2 | 0 free, 1 opcode fetch, 2/3 data access |
| cof | input | 1 | Change-of-flow flag |
| pc | input | AW | Program counter |
| addr | input | AW | Bus address |
| data | input | DW | Bus data |
| rd_en | input | 1 | Read one entry |
| rd_data | output | AW+DW | Entry read, {address field, data field} |
| count | output | $clog2(DEPTH+1) | Stored entry count |
| armed | output | 1 | Session armed |
| done | output | 1 | Session finished |
| brk_req | output | 1 | Breakpoint request |

## Verification
The bench builds the block with DEPTH=8, AW=16 and DW=8. The small depth lets a short run fill the buffer, saturate the count and wrap the write pointer several times. With it the full-stop of begin alignment and the oldest-first unwrap after an end-aligned trigger are both checked against values computed in the bench. The 16-bit fields keep the program counter and address values distinct, so dropped or reordered entries show up in the readback.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam logic [1:0] MODE_COF      = 2'd0;
  localparam logic [1:0] MODE_COF_DEDUP = 2'd1;
  localparam logic [1:0] MODE_DETAIL   = 2'd2;
  localparam logic [1:0] MODE_ALLPC    = 2'd3;

  localparam logic [1:0] CYC_IDLE  = 2'd0;
  localparam logic [1:0] CYC_FETCH = 2'd1;
endpackage

// File: rtl/trc_filter.sv
module trc_filter import trc_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int EW = AW + DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic [1:0]    mode,
  input  logic          bus_valid,
  input  logic [1:0]    cyc_type,
  input  logic          cof,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          commit,
  output logic          hit,
  output logic [EW-1:0] entry
);
  logic [AW-1:0] last_pc;
  logic          last_vld;
  logic          dup;

  assign dup = last_vld && (pc == last_pc);

  always_comb begin
    hit   = 1'b0;
    entry = {pc, {DW{1'b0}}};
    unique case (mode)
      MODE_COF:       hit = bus_valid && cof;
      MODE_COF_DEDUP: hit = bus_valid && cof && !dup;
      MODE_DETAIL: begin
        hit   = bus_valid && (cyc_type != CYC_IDLE) && (cyc_type != CYC_FETCH);
        entry = {addr, data};
      end
      default:        hit = bus_valid && (cyc_type == CYC_FETCH);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      last_vld <= 1'b0;
      last_pc  <= '0;
    end else if (commit && (mode != MODE_DETAIL)) begin
      last_vld <= 1'b1;
      last_pc  <= pc;
    end
  end
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl #(
  parameter int DEPTH = 64,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_set,
  input  logic          arm_clr,
  input  logic          align_end,
  input  logic          trigger,
  input  logic          gate_ok,
  input  logic          hit,
  output logic          commit,
  output logic [PW-1:0] wptr,
  output logic [CW-1:0] count,
  output logic          armed,
  output logic          done,
  output logic          brk_req
);
  logic recording;
  logic align_q;
  logic last_slot;

  assign commit    = armed && !arm_set && (recording || trigger) && gate_ok && hit;
  assign last_slot = (count == CW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      recording <= 1'b0;
      align_q   <= 1'b0;
      done      <= 1'b0;
      count     <= '0;
      wptr      <= '0;
      brk_req   <= 1'b0;
    end else if (arm_set) begin
      armed     <= 1'b1;
      recording <= align_end;
      align_q   <= align_end;
      done      <= 1'b0;
      count     <= '0;
      wptr      <= '0;
      brk_req   <= 1'b0;
    end else begin
      brk_req <= armed && trigger;
      if (commit) begin
        wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        if (count != CW'(DEPTH))
          count <= count + 1'b1;
      end
      if (armed) begin
        if (arm_clr) begin
          armed     <= 1'b0;
          recording <= 1'b0;
        end else begin
          if (trigger) begin
            if (align_q) begin
              armed     <= 1'b0;
              recording <= 1'b0;
              done      <= 1'b1;
            end else begin
              recording <= 1'b1;
            end
          end
          if (!align_q && commit && last_slot) begin
            armed     <= 1'b0;
            recording <= 1'b0;
            done      <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/trc_buf.sv
module trc_buf #(
  parameter int DEPTH = 64,
  parameter int EW = 24,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic          re,
  input  logic [PW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (re)
      rdata <= mem[raddr];
  end
endmodule

// File: rtl/trace_capture.sv
module trace_capture #(
  parameter int DEPTH = 64,
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int EW = AW + DW,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_set,
  input  logic          arm_clr,
  input  logic          align_end,
  input  logic [1:0]    mode,
  input  logic          trigger,
  input  logic          secure,
  input  logic          dbg_active,
  input  logic          bus_valid,
  input  logic [1:0]    cyc_type,
  input  logic          cof,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          rd_en,
  output logic [EW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          armed,
  output logic          done,
  output logic          brk_req
);
  logic          hit;
  logic          commit;
  logic [EW-1:0] entry;
  logic [PW-1:0] wptr;
  logic [PW-1:0] rofs;
  logic [PW-1:0] oldest;
  logic [PW:0]   rsum;
  logic [PW-1:0] raddr;
  logic          re;

  trc_filter #(.AW(AW), .DW(DW)) u_filter (
    .clk(clk), .rst(rst), .clear(arm_set), .mode(mode),
    .bus_valid(bus_valid), .cyc_type(cyc_type), .cof(cof),
    .pc(pc), .addr(addr), .data(data), .commit(commit),
    .hit(hit), .entry(entry)
  );

  trc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .arm_set(arm_set), .arm_clr(arm_clr),
    .align_end(align_end), .trigger(trigger),
    .gate_ok(!secure && !dbg_active), .hit(hit), .commit(commit),
    .wptr(wptr), .count(count), .armed(armed), .done(done), .brk_req(brk_req)
  );

  assign re     = rd_en && !armed;
  assign oldest = (count == CW'(DEPTH)) ? wptr : '0;
  assign rsum   = {1'b0, oldest} + {1'b0, rofs};
  assign raddr  = (rsum >= (PW+1)'(DEPTH)) ? PW'(rsum - (PW+1)'(DEPTH)) : PW'(rsum);

  always_ff @(posedge clk) begin
    if (rst || arm_set || arm_clr)
      rofs <= '0;
    else if (re)
      rofs <= (rofs == PW'(DEPTH - 1)) ? '0 : rofs + 1'b1;
  end

  trc_buf #(.DEPTH(DEPTH), .EW(EW)) u_buf (
    .clk(clk), .rst(rst), .we(commit), .waddr(wptr), .wdata(entry),
    .re(re), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int DEPTH = 64,
  parameter int EW = 24,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          arm_set,
  input logic          trigger,
  input logic          secure,
  input logic          dbg_active,
  input logic          armed,
  input logic          done,
  input logic          brk_req,
  input logic [CW-1:0] count,
  input logic [EW-1:0] rd_data
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (count == '0 && !armed && !done && !brk_req)); // R1
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH)); // R11
  AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (rst) done |-> !armed); // R6
  AST_SECURE_HOLD: assert property (@(posedge clk) disable iff (rst) (secure && !arm_set) |=> $stable(count)); // R8
  AST_SECURE_BRK: assert property (@(posedge clk) disable iff (rst) (armed && trigger && !arm_set) |=> brk_req); // R8
  AST_DBG_HOLD: assert property (@(posedge clk) disable iff (rst) (dbg_active && !arm_set) |=> $stable(count)); // R9
  AST_READ_LOCKED: assert property (@(posedge clk) disable iff (rst) armed |=> $stable(rd_data)); // R10
endmodule

bind trace_capture trc_checker #(.DEPTH(DEPTH), .EW(EW)) u_trc_checker (
  .clk(clk), .rst(rst), .arm_set(arm_set), .trigger(trigger), .secure(secure),
  .dbg_active(dbg_active), .armed(armed), .done(done), .brk_req(brk_req),
  .count(count), .rd_data(rd_data)
);

// File: tb/test_trace_capture.sv
module test_trace_capture;
  localparam int DEPTH = 8;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int EW = AW + DW;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          arm_set = 0, arm_clr = 0, align_end = 0, trigger = 0;
  logic          secure = 0, dbg_active = 0, bus_valid = 0, cof = 0, rd_en = 0;
  logic [1:0]    mode = 0, cyc_type = 0;
  logic [AW-1:0] pc = 0, addr = 0;
  logic [DW-1:0] data = 0;
  logic [EW-1:0] rd_data;
  logic [CW-1:0] count;
  logic          armed, done, brk_req;

  int n_checks = 0;
  int n_fail = 0;
  logic [EW-1:0] exp_q[$];

  always #4 clk = ~clk;

  trace_capture #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_trace_capture (
    .clk(clk), .rst(rst), .arm_set(arm_set), .arm_clr(arm_clr),
    .align_end(align_end), .mode(mode), .trigger(trigger), .secure(secure),
    .dbg_active(dbg_active), .bus_valid(bus_valid), .cyc_type(cyc_type),
    .cof(cof), .pc(pc), .addr(addr), .data(data), .rd_en(rd_en),
    .rd_data(rd_data), .count(count), .armed(armed), .done(done), .brk_req(brk_req)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus(input logic [1:0] ct, input logic cf, input logic [AW-1:0] p,
                     input logic [AW-1:0] a, input logic [DW-1:0] d, input logic trg);
    bus_valid = 1; cyc_type = ct; cof = cf; pc = p; addr = a; data = d; trigger = trg;
    tick();
    bus_valid = 0; cof = 0; trigger = 0;
  endtask

  task automatic arm(input logic [1:0] m, input logic al);
    mode = m; align_end = al; arm_set = 1;
    tick();
    arm_set = 0;
    exp_q.delete();
  endtask

  task automatic pulse_trigger();
    trigger = 1; tick(); trigger = 0;
  endtask

  task automatic read_back(input string req);
    arm_clr = 1; tick(); arm_clr = 0;
    foreach (exp_q[i]) begin
      rd_en = 1; tick();
      check(req, $sformatf("entry %0d", i), 32'(rd_data), 32'(exp_q[i]));
    end
    rd_en = 0;
  endtask

  task automatic t_reset();
    check("R1", "armed", 32'(armed), 0);
    check("R1", "done", 32'(done), 0);
    check("R1", "count", 32'(count), 0);
    check("R1", "brk_req", 32'(brk_req), 0);
  endtask

  task automatic t_normal();
    logic [EW-1:0] held;
    arm(2'd0, 1'b0);
    bus(2'd1, 1, 16'h0050, 0, 0, 0);
    check("R6", "count before trigger", 32'(count), 0);
    bus(2'd1, 1, 16'h0100, 0, 0, 1);
    check("R8", "brk_req after trigger", 32'(brk_req), 1);
    bus(2'd1, 0, 16'h0102, 0, 0, 0);
    bus(2'd2, 1, 16'h0200, 16'h1234, 8'h55, 0);
    exp_q.push_back({16'h0100, 8'h00});
    exp_q.push_back({16'h0200, 8'h00});
    check("R2", "cof count", 32'(count), 2);
    held = rd_data;
    rd_en = 1; tick(); tick(); rd_en = 0;
    check("R10", "read while armed", 32'(rd_data), 32'(held));
    read_back("R2");
  endtask

  task automatic t_loop1();
    arm(2'd1, 1'b0);
    pulse_trigger();
    bus(2'd1, 1, 16'h0300, 0, 0, 0);
    bus(2'd1, 1, 16'h0300, 0, 0, 0);
    bus(2'd1, 1, 16'h0310, 0, 0, 0);
    bus(2'd1, 1, 16'h0300, 0, 0, 0);
    check("R3", "dedup count", 32'(count), 3);
    exp_q.push_back({16'h0300, 8'h00});
    exp_q.push_back({16'h0310, 8'h00});
    exp_q.push_back({16'h0300, 8'h00});
    read_back("R3");
  endtask

  task automatic t_detail();
    arm(2'd2, 1'b0);
    pulse_trigger();
    bus(2'd0, 0, 16'h0001, 16'h0010, 8'h01, 0);
    bus(2'd1, 1, 16'h0002, 16'h0011, 8'h02, 0);
    bus(2'd2, 0, 16'h0003, 16'h0020, 8'hAA, 0);
    bus(2'd3, 1, 16'h0004, 16'h0030, 8'hBB, 0);
    check("R4", "detail count", 32'(count), 2);
    exp_q.push_back({16'h0020, 8'hAA});
    exp_q.push_back({16'h0030, 8'hBB});
    read_back("R4");
  endtask

  task automatic t_purepc();
    arm(2'd3, 1'b0);
    pulse_trigger();
    bus(2'd1, 0, 16'h0400, 0, 0, 0);
    bus(2'd1, 0, 16'h0402, 0, 0, 0);
    bus(2'd2, 1, 16'h0404, 16'h0404, 8'h9, 0);
    bus(2'd1, 1, 16'h0406, 0, 0, 0);
    check("R5", "fetch count", 32'(count), 3);
    exp_q.push_back({16'h0400, 8'h00});
    exp_q.push_back({16'h0402, 8'h00});
    exp_q.push_back({16'h0406, 8'h00});
    read_back("R5");
  endtask

  task automatic t_gates();
    arm(2'd0, 1'b0);
    secure = 1;
    bus(2'd1, 1, 16'h0500, 0, 0, 1);
    check("R8", "brk_req while secure", 32'(brk_req), 1);
    check("R8", "count while secure", 32'(count), 0);
    bus(2'd1, 1, 16'h0502, 0, 0, 0);
    secure = 0;
    check("R8", "count after secure", 32'(count), 0);
    dbg_active = 1;
    bus(2'd1, 1, 16'h0504, 0, 0, 0);
    dbg_active = 0;
    check("R9", "count while debug active", 32'(count), 0);
    bus(2'd1, 1, 16'h0506, 0, 0, 0);
    check("R9", "count after debug active", 32'(count), 1);
    exp_q.push_back({16'h0506, 8'h00});
    read_back("R9");
  endtask

  task automatic t_begin_full();
    arm(2'd3, 1'b0);
    pulse_trigger();
    for (int i = 0; i < DEPTH + 2; i++) begin
      bus(2'd1, 0, 16'(16'h0600 + 2 * i), 0, 0, 0);
      if (i < DEPTH) exp_q.push_back({16'(16'h0600 + 2 * i), 8'h00});
      if (i == DEPTH - 2) check("R6", "armed before full", 32'(armed), 1);
    end
    check("R11", "count saturated", 32'(count), DEPTH);
    check("R6", "done when full", 32'(done), 1);
    check("R6", "disarmed when full", 32'(armed), 0);
    read_back("R6");
  endtask

  task automatic t_end_align();
    arm(2'd3, 1'b1);
    for (int i = 0; i < 12; i++)
      bus(2'd1, 0, 16'(16'h0700 + 2 * i), 0, 0, 0);
    check("R11", "count wraps saturated", 32'(count), DEPTH);
    check("R7", "still armed", 32'(armed), 1);
    bus(2'd1, 0, 16'h07F0, 0, 0, 1);
    check("R7", "done at trigger", 32'(done), 1);
    check("R7", "disarmed at trigger", 32'(armed), 0);
    bus(2'd1, 0, 16'h07F2, 0, 0, 0);
    for (int i = 12 - DEPTH + 1; i < 12; i++)
      exp_q.push_back({16'(16'h0700 + 2 * i), 8'h00});
    exp_q.push_back({16'h07F0, 8'h00});
    read_back("R7");
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 0;
    tick();
    t_reset();
    t_normal();
    t_loop1();
    t_detail();
    t_purepc();
    t_gates();
    t_begin_full();
    t_end_align();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule